// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an effective address into a real address by walking a radix tree of translation directories held in memory. A walk starts from a root table base, a root index width and the size of the address region the root covers. At each level the walker first confirms that the tree shape is one it supports. It then cuts the index for that level out of the effective address, reads the 64-bit directory entry through a single-request memory port, and either descends to the next directory or finishes on a leaf.

A walk ends in one of three ways. A leaf entry produces a real address and the page size still left. A missing valid bit produces an invalid-entry fault. A tree shape outside the fixed per-level table produces a bad-configuration fault, raised before any read is issued for that level. Only one walk runs at a time. The result is reported with a one-cycle completion pulse and held until the next walk completes.

Top module: `radix_walker`

## Requirements
- R1: A start request is taken only while the walker is idle (`busy` low). A start request seen while busy has no effect on the walk in progress or on its result.
- R2: The level counter is 0 for the first fetch of a walk. At level 0 the shape is accepted only if the remaining size is 52 and the index width is 13.
- R3: At levels 1 and 2 the shape is accepted only if the index width is exactly 9.
- R4: At level 3 the shape is accepted if the index width is 9 or 5. Any level of 4 or above is rejected.
- R5: The shape check for a level completes before that level's read. A rejected shape issues no read for that level and ends the walk with `faultCause` = 2'b01 (bit 0, bad configuration) and `fault` high.
- R6: The entry address is the table base plus 8 times the index. The index is the effective address shifted right by (remaining size − index width) and masked to its low index-width bits.
- R7: Bit 63 of an entry is its valid bit. A clear valid bit ends the walk with `faultCause` = 2'b10 (bit 1, invalid entry) and `fault` high.
- R8: Each fetched valid entry reduces the remaining size by the current index width. In a valid entry with bit 62 (leaf) clear, bits 55:8 give the next table base (low 8 bits zero) and bits 4:0 give the next index width.
- R9: On a valid entry with bit 62 set, `realAddr` is the page address (entry bits 55:12, low 12 bits zero) with its low (remaining size) bits replaced by the effective address's bits. `pageSize` is the remaining size. `fault` and `faultCause` read zero.
- R10: `done` is high for exactly one cycle per walk. `fault`, `faultCause`, `realAddr` and `pageSize` hold their values until the next completion. On a fault, `realAddr` and `pageSize` read zero.
- R11: A request holds `memReqValid` and `memReqAddr` steady until `memReqReady` accepts it. At most one read is outstanding, and its response is taken when `memRspValid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start a walk (taken only when idle) |
| startEa | input | 64 | Effective address to translate |
| rootBase | input | 56 | Root directory base address |
| rootNls | input | 5 | Root index width |
| rootSize | input | 6 | Address size covered by the root |
| memReqValid | output | 1 | Entry read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 56 | Entry address being read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Directory entry read |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completed walk ended in a fault |
| faultCause | output | 2 | One-hot cause: bit 0 bad configuration, bit 1 invalid entry |
| realAddr | output | 56 | Translated real address |
| pageSize | output | 6 | Remaining size at the leaf (log2 of page size) |

## Verification
The bench builds the walker with its default widths: a 64-bit effective address and a 56-bit real address. These widths let the root cover the full 52-bit region and let leaf pages range from 39 bits at the root down to 12 or 16 bits at level 3. The bench fills a sparse memory along each walk's path as it goes. This brings within reach bad shapes at every level, the forced rejection at level 4, leaves at every depth, invalid entries mid-walk, and starts pulsed while a walk is running, all under randomly stalled request acceptance and response delays.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int ENTRY_W   = 64;
  localparam int VALID_BIT = 63;
  localparam int LEAF_BIT  = 62;
  localparam int BASE_LSB  = 8;
  localparam int PAGE_LSB  = 12;
  localparam int CAUSE_W   = 2;
  localparam int CAUSE_BAD = 0;
  localparam int CAUSE_INV = 1;
  localparam int MID_NLS   = 9;
  localparam int ALT_NLS   = 5;
  localparam int LAST_LVL  = 3;

  typedef struct packed {
    logic load;
    logic descend;
    logic finLeaf;
    logic finBad;
    logic finInvalid;
  } rwStrobes_t;
endpackage

// File: rtl/rw_ctrl.sv
module rw_ctrl
  import rw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       shapeOk,
  input  logic       entryValid,
  input  logic       entryLeaf,
  output rwStrobes_t strobes,
  output logic       memReqValid,
  output logic       busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_REQ, ST_WAIT} walkState_t;
  walkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (startValid) begin
        strobes.load = 1'b1;
        stateNext    = ST_CHECK;
      end
      ST_CHECK: if (shapeOk) begin
        stateNext = ST_REQ;
      end else begin
        strobes.finBad = 1'b1;
        stateNext      = ST_IDLE;
      end
      ST_REQ: if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (memRspValid) begin
        if (!entryValid) begin
          strobes.finInvalid = 1'b1;
          stateNext          = ST_IDLE;
        end else if (entryLeaf) begin
          strobes.finLeaf = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          strobes.descend = 1'b1;
          stateNext       = ST_CHECK;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memReqValid = (state == ST_REQ);
  assign busy        = (state != ST_IDLE);

  a_r5_no_read_on_bad: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && !shapeOk) |=> !memReqValid);
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);
  a_r1_start_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startValid && !strobes.finBad && !strobes.finLeaf && !strobes.finInvalid) |=> busy);
endmodule

// File: rtl/rw_datapath.sv
module rw_datapath
  import rw_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int PA_W      = 56,
  parameter int SIZE_W    = 6,
  parameter int NLS_W     = 5,
  parameter int LVL_W     = 3,
  parameter int ROOT_SIZE = 52,
  parameter int ROOT_NLS  = 13
)(
  input  logic               clk,
  input  logic               rstN,
  input  rwStrobes_t         strobes,
  input  logic [EA_W-1:0]    startEa,
  input  logic [PA_W-1:0]    rootBase,
  input  logic [NLS_W-1:0]   rootNls,
  input  logic [SIZE_W-1:0]  rootSize,
  input  logic [ENTRY_W-1:0] rspData,
  output logic               shapeOk,
  output logic               entryValid,
  output logic               entryLeaf,
  output logic [PA_W-1:0]    reqAddr,
  output logic               done,
  output logic               fault,
  output logic [CAUSE_W-1:0] faultCause,
  output logic [PA_W-1:0]    realAddr,
  output logic [SIZE_W-1:0]  pageSize
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic [EA_W-1:0]   eaQ;
  logic [PA_W-1:0]   baseQ;
  logic [NLS_W-1:0]  nlsQ;
  logic [SIZE_W-1:0] sizeQ;
  logic [LVL_W-1:0]  lvlQ;

  // shape table, one row per level
  always_comb begin
    case (lvlQ)
      LVL_W'(0): shapeOk = (sizeQ == SIZE_W'(ROOT_SIZE)) && (nlsQ == NLS_W'(ROOT_NLS));
      LVL_W'(1),
      LVL_W'(2): shapeOk = (nlsQ == NLS_W'(MID_NLS));
      LVL_W'(LAST_LVL): shapeOk = (nlsQ == NLS_W'(MID_NLS)) || (nlsQ == NLS_W'(ALT_NLS));
      default:   shapeOk = 1'b0;
    endcase
  end

  logic [SIZE_W-1:0] shiftAmt, newSize;
  logic [EA_W-1:0]   shifted, idxMask, idx;
  assign shiftAmt = sizeQ - SIZE_W'(nlsQ);
  assign newSize  = shiftAmt;
  assign shifted  = eaQ >> shiftAmt;
  assign idxMask  = (EA_W'(1) << nlsQ) - EA_W'(1);
  assign idx      = shifted & idxMask;
  assign reqAddr  = baseQ + (PA_W'(idx) << 3);

  assign entryValid = rspData[VALID_BIT];
  assign entryLeaf  = rspData[LEAF_BIT];

  logic [PA_W-1:0] pageAddr, lowMask, leafAddr, nextBase;
  assign pageAddr = {rspData[PA_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
  assign nextBase = {rspData[PA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
  assign lowMask  = (PA_W'(1) << newSize) - PA_W'(1);
  assign leafAddr = (pageAddr & ~lowMask) | (eaQ[PA_W-1:0] & lowMask);

  logic unusedEntryBits;
  assign unusedEntryBits = ^{rspData[LEAF_BIT-1:PA_W], rspData[BASE_LSB-1:NLS_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ   <= '0;
      baseQ <= '0;
      nlsQ  <= '0;
      sizeQ <= '0;
      lvlQ  <= '0;
    end else if (strobes.load) begin
      eaQ   <= startEa;
      baseQ <= rootBase;
      nlsQ  <= rootNls;
      sizeQ <= rootSize;
      lvlQ  <= '0;
    end else if (strobes.descend) begin
      baseQ <= nextBase;
      nlsQ  <= rspData[NLS_W-1:0];
      sizeQ <= newSize;
      if (lvlQ != LVL_MAX) lvlQ <= lvlQ + LVL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done       <= 1'b0;
      fault      <= 1'b0;
      faultCause <= '0;
      realAddr   <= '0;
      pageSize   <= '0;
    end else begin
      done <= strobes.finLeaf | strobes.finBad | strobes.finInvalid;
      if (strobes.finLeaf) begin
        fault      <= 1'b0;
        faultCause <= '0;
        realAddr   <= leafAddr;
        pageSize   <= newSize;
      end else if (strobes.finBad || strobes.finInvalid) begin
        fault      <= 1'b1;
        faultCause <= '0;
        faultCause[CAUSE_BAD] <= strobes.finBad;
        faultCause[CAUSE_INV] <= strobes.finInvalid;
        realAddr   <= '0;
        pageSize   <= '0;
      end
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(realAddr) && $stable(faultCause) && $stable(pageSize)));
  a_r7_cause_onehot: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($onehot0(faultCause) && (fault == (faultCause != '0))));
  a_r4_deep_level_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (lvlQ > LVL_W'(LAST_LVL)) |-> !shapeOk);
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rw_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int PA_W      = 56,
  parameter int SIZE_W    = 6,
  parameter int NLS_W     = 5,
  parameter int LVL_W     = 3,
  parameter int ROOT_SIZE = 52,
  parameter int ROOT_NLS  = 13
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic [EA_W-1:0]    startEa,
  input  logic [PA_W-1:0]    rootBase,
  input  logic [NLS_W-1:0]   rootNls,
  input  logic [SIZE_W-1:0]  rootSize,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [PA_W-1:0]    memReqAddr,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic               busy,
  output logic               done,
  output logic               fault,
  output logic [CAUSE_W-1:0] faultCause,
  output logic [PA_W-1:0]    realAddr,
  output logic [SIZE_W-1:0]  pageSize
);
  rwStrobes_t strobes;
  logic shapeOk, entryValid, entryLeaf;

  rw_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .shapeOk(shapeOk), .entryValid(entryValid), .entryLeaf(entryLeaf),
    .strobes(strobes), .memReqValid(memReqValid), .busy(busy)
  );

  rw_datapath #(
    .EA_W(EA_W), .PA_W(PA_W), .SIZE_W(SIZE_W), .NLS_W(NLS_W), .LVL_W(LVL_W),
    .ROOT_SIZE(ROOT_SIZE), .ROOT_NLS(ROOT_NLS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .startEa(startEa), .rootBase(rootBase), .rootNls(rootNls), .rootSize(rootSize),
    .rspData(memRspData), .shapeOk(shapeOk), .entryValid(entryValid),
    .entryLeaf(entryLeaf), .reqAddr(memReqAddr), .done(done), .fault(fault),
    .faultCause(faultCause), .realAddr(realAddr), .pageSize(pageSize)
  );

  a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));
endmodule

// File: tb/radix_walker_tb_top.sv
module radix_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [63:0] startEa = '0;
  logic [55:0] rootBase = '0;
  logic [4:0]  rootNls = '0;
  logic [5:0]  rootSize = '0;
  logic        memReqValid, memReqReady, memRspValid;
  logic [55:0] memReqAddr;
  logic [63:0] memRspData;
  logic        busy, done, fault;
  logic [1:0]  faultCause;
  logic [55:0] realAddr;
  logic [5:0]  pageSize;

  always #(CLK_PERIOD/2) clk = ~clk;

  radix_walker dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startEa(startEa),
    .rootBase(rootBase), .rootNls(rootNls), .rootSize(rootSize),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .busy(busy), .done(done),
    .fault(fault), .faultCause(faultCause), .realAddr(realAddr), .pageSize(pageSize)
  );

  int errors = 0;
  int checks = 0;
  logic [63:0] memArr [logic [55:0]];
  int          readCount = 0;
  logic [55:0] firstAddr;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory responder: random accept, random latency
  initial begin
    bit          taken = 0;
    bit          pending = 0;
    int          delay = 0;
    logic [55:0] pendAddr = '0;
    memReqReady = 1'b0;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (taken) begin
        pending = 1; delay = $urandom % 3; taken = 0;
      end
      if (pending) begin
        memReqReady = 1'b0;
        if (delay == 0) begin
          memRspValid = 1'b1;
          memRspData  = memArr.exists(pendAddr) ? memArr[pendAddr] : 64'h0;
          pending = 0;
        end else delay--;
      end else begin
        memReqReady = ($urandom % 3) != 0;
      end
      if (memReqValid && memReqReady) begin
        taken = 1;
        pendAddr = memReqAddr;
        if (readCount == 0) firstAddr = memReqAddr;
        readCount++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  function automatic bit shapeRef(int lvl, int size, int nls);
    if (lvl == 0) return size == 52 && nls == 13;
    if (lvl == 1 || lvl == 2) return nls == 9;
    if (lvl == 3) return nls == 9 || nls == 5;
    return 0;
  endfunction

  function automatic logic [55:0] randBase();
    logic [55:0] b;
    b = {$urandom, $urandom};
    b[7:0] = '0;
    return b;
  endfunction

  // builds entries along the path and predicts the outcome
  task automatic planWalk(input logic [63:0] ea, input logic [55:0] base0, input int nls0,
      input int size0, input int badLvl, input int badNls, input int invLvl, input int leafLvl,
      input int nls3, output logic [1:0] cause, output logic [55:0] ra, output int ps,
      output int reads, output logic [55:0] addr0);
    logic [55:0] base = base0;
    int nls = nls0, size = size0;
    cause = 2'b00; ra = '0; ps = 0; reads = 0; addr0 = '0;
    for (int lvl = 0; lvl < 8; lvl++) begin
      logic [63:0] idx, e;
      logic [55:0] addr;
      if (!shapeRef(lvl, size, nls)) begin cause = 2'b01; return; end
      idx  = (ea >> (size - nls)) & ((64'd1 << nls) - 64'd1);
      addr = base + 56'(idx * 8);
      if (reads == 0) addr0 = addr;
      reads++;
      if (!memArr.exists(addr)) begin
        int nn = (lvl + 1 == badLvl) ? badNls : ((lvl + 1 == 3) ? nls3 : 9);
        e = '0;
        e[63] = (lvl != invLvl);
        e[62] = (lvl == leafLvl);
        e[55:8] = randBase() >> 8;
        if (lvl == leafLvl) e[11:8] = 4'($urandom);
        e[4:0] = 5'(nn);
        memArr[addr] = e;
      end
      e = memArr[addr];
      if (!e[63]) begin cause = 2'b10; return; end
      size = size - nls;
      if (e[62]) begin
        logic [55:0] pg, m;
        pg = {e[55:12], 12'h0};
        m  = (56'd1 << size) - 56'd1;
        ra = (pg & ~m) | (ea[55:0] & m);
        ps = size;
        return;
      end
      base = {e[55:8], 8'h0};
      nls  = int'(e[4:0]);
    end
  endtask

  task automatic runWalk(input string tag, input logic [63:0] ea, input int nls0, input int size0,
      input int badLvl, input int badNls, input int invLvl, input int leafLvl, input int nls3,
      input bit inject);
    logic [1:0]  expCause;
    logic [55:0] expRa, addr0, base0;
    int expPs, expReads, waited;
    base0 = randBase();
    memArr.delete();
    planWalk(ea, base0, nls0, size0, badLvl, badNls, invLvl, leafLvl, nls3,
             expCause, expRa, expPs, expReads, addr0);
    @(negedge clk);
    readCount  = 0;
    startValid = 1'b1; startEa = ea; rootBase = base0;
    rootNls = 5'(nls0); rootSize = 6'(size0);
    @(negedge clk);
    startValid = 1'b0;
    startEa = {$urandom, $urandom}; rootBase = randBase(); rootNls = 5'd13; rootSize = 6'd52;
    waited = 0;
    while (!done && waited < 300) begin
      if (inject && waited == 2 && busy) startValid = 1'b1;
      else startValid = 1'b0;
      @(negedge clk);
      waited++;
    end
    startValid = 1'b0;
    check(done === 1'b1, {tag, " R10 done seen"}, 64'(done), 64'd1);
    check(faultCause === expCause, {tag, " R5/R7 faultCause"}, 64'(faultCause), 64'(expCause));
    check(fault === (expCause != 0), {tag, " R5 fault flag"}, 64'(fault), 64'(expCause != 0));
    check(realAddr === expRa, {tag, " R9 realAddr"}, 64'(realAddr), 64'(expRa));
    check(pageSize === 6'(expPs), {tag, " R9 pageSize"}, 64'(pageSize), 64'(expPs));
    check(readCount == expReads, {tag, " R5 read count"}, 64'(readCount), 64'(expReads));
    if (expReads > 0)
      check(firstAddr === addr0, {tag, " R6 first entry address"}, 64'(firstAddr), 64'(addr0));
    if (inject)
      check(realAddr === expRa && faultCause === expCause, {tag, " R1 start while busy ignored"},
            64'(realAddr), 64'(expRa));
    @(negedge clk);
    check(done === 1'b0, {tag, " R10 done one cycle"}, 64'(done), 64'd0);
    check(realAddr === expRa && faultCause === expCause, {tag, " R10 result held"},
          64'(realAddr), 64'(expRa));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(done === 1'b0 && busy === 1'b0 && memReqValid === 1'b0, "reset R10 outputs idle",
          64'({done, busy, memReqValid}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(faultCause === 2'b00 && realAddr === '0, "reset R10 results zero",
          64'(realAddr), 64'd0);
    // directed
    runWalk("R2 root idx 12",      64'h0123_4567_89ab_cdef, 12, 52, -1, 0, -1, 3, 9, 0);
    runWalk("R2 root size 48",     64'h0123_4567_89ab_cdef, 13, 48, -1, 0, -1, 3, 9, 0);
    runWalk("R2 leaf at root",     64'h000f_ffff_ffff_ffff, 13, 52, -1, 0, -1, 0, 9, 0);
    runWalk("R3 bad level1",       64'h0002_3456_789a_bcde, 13, 52, 1, 7, -1, 3, 9, 0);
    runWalk("R3 bad level2",       64'h0002_3456_789a_bcde, 13, 52, 2, 5, -1, 3, 9, 0);
    runWalk("R4 level3 idx5 leaf", 64'h000a_bcde_f012_3456, 13, 52, -1, 0, -1, 3, 5, 0);
    runWalk("R4 level3 idx9 leaf", 64'h000a_bcde_f012_3456, 13, 52, -1, 0, -1, 3, 9, 0);
    runWalk("R4 level3 idx13 bad", 64'h000a_bcde_f012_3456, 13, 52, 3, 13, -1, 3, 9, 0);
    runWalk("R4 level4 rejected",  64'h0005_5555_aaaa_5555, 13, 52, -1, 0, -1, -1, 9, 0);
    runWalk("R7 invalid level2",   64'h0001_1111_2222_3333, 13, 52, -1, 0, 2, 3, 9, 0);
    runWalk("R8 leaf level1",      64'h0007_7777_8888_9999, 13, 52, -1, 0, -1, 1, 9, 0);
    runWalk("R1 inject",           64'h0003_3333_4444_5555, 13, 52, -1, 0, -1, 3, 9, 1);
    // random
    for (int i = 0; i < 300; i++) begin
      int sel = $urandom % 10;
      int n0 = 13, s0 = 52, bl = -1, bn = 0, il = -1, ll = $urandom % 5, n3;
      n3 = ($urandom % 2) ? 9 : 5;
      if (ll == 4) ll = -1;
      if (sel == 0) begin if ($urandom % 2) n0 = $urandom % 32; else s0 = $urandom % 64; end
      if (sel == 1) begin bl = 1 + $urandom % 3; bn = ($urandom % 2) ? 7 : 13; end
      if (sel == 2) il = $urandom % 4;
      runWalk("rand R6 R8 R9", {$urandom, $urandom}, n0, s0, bl, bn, il, ll, n3, ($urandom % 4) == 0);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule